// File: doc/BRIEF.md
# One-Wire Search Triplet Sequencer

This block handles one bit position of a one-wire ROM search. When a requester pulses `start_i` and supplies a preferred direction bit, the block asks the bit-level layer below it for three time slots in turn: two read slots, then one write slot. It waits for the bit layer's `slot_done_i` handshake after each request. The two bits it reads form a 2-bit status code. The value sent in the write slot is chosen from that code. When the write slot is acknowledged, the block returns the code to the requester together with a one-cycle `done_o` pulse.

The block does not handle analog slot timing, bus reset, presence detection or byte transfers. The bit layer owns all of these. The sequencer only orders the slots, collects the two answer bits and decides which bit the write slot carries. Seen from the requester, one call is a fixed three-slot transaction whose length depends only on how long the bit layer takes per slot.

Top module: `ow_triplet_seq`

## Requirements
- R1: Each accepted start produces exactly two read-slot requests followed by one write-slot request. At most one request (`rd_req_o` or `wr_req_o`) is high at a time, and each request stays high until the cycle in which `slot_done_i` is sampled high.
- R2: The bit returned with the first read slot is placed in `status_o[1]`, and the bit returned with the second read slot is placed in `status_o[0]`.
- R3: When the status is 2'b00, `wr_bit_o` during the write slot equals the `dir_i` value sampled with the accepted start.
- R4: When the status is 2'b01, `wr_bit_o` during the write slot is 0.
- R5: When the status is 2'b10 or 2'b11, `wr_bit_o` during the write slot is 1. Status 2'b11 is reported unchanged, and its write slot is still issued.
- R6: `done_o` is high for exactly one cycle, the cycle after the write slot's `slot_done_i` is sampled. `status_o` holds the final code in that cycle and keeps it until the next accepted start's first read completes.
- R7: `start_i` is ignored while `busy_o` is high, and `slot_done_i` is ignored when no request is pending. Neither adds slots nor changes `status_o`.
- R8: After reset, `busy_o`, `rd_req_o`, `wr_req_o`, `done_o` and `status_o` are all 0.
- R9: The first read request rises the cycle after `start_i` is sampled, and each following request rises the cycle after the previous `slot_done_i`. With a bit layer that acknowledges after L cycles, `done_o` is therefore due 3L+3 cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts one triplet operation when the block is idle |
| dir_i | input | 1 | Preferred direction bit, sampled with the accepted start |
| busy_o | output | 1 | High from the cycle after the accepted start through the done cycle |
| rd_req_o | output | 1 | Read-slot request to the bit layer |
| wr_req_o | output | 1 | Write-slot request to the bit layer |
| wr_bit_o | output | 1 | Bit value for the pending write slot |
| slot_done_i | input | 1 | Bit-layer acknowledge of the pending slot |
| rd_bit_i | input | 1 | Bit read in the slot, valid while `slot_done_i` is high |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Status code: first read in bit 1, second read in bit 0 |

## Verification
The bench includes a bit-layer model whose acknowledge latency can be set. From that latency it computes when `done_o` must appear after the start edge: 3L+3 negative edges, since each slot after the first costs one extra cycle while the previous acknowledge drops. It then counts negative edges and requires the pulse on exactly that edge and on no other. The model logs every slot type and every write bit at the moment it acknowledges, so the slot order and the chosen write value are checked against the acknowledged slot itself rather than a later snapshot. All outputs are sampled on the falling edge, half a cycle after the registers that drive them have settled. Idle checks run several cycles past the event so that a late, unwanted slot would still be caught.

// File: rtl/ow_trip_pkg.sv
package ow_trip_pkg;

  localparam int STATUS_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READA = 3'd1,
    ST_READB = 3'd2,
    ST_WRITE = 3'd3,
    ST_FIN   = 3'd4
  } seq_state_t;

  // Write-bit choice from the collected answer pair and the preferred direction.
  function automatic logic pick_write_bit(input logic [STATUS_W-1:0] code,
                                          input logic                dir);
    logic result;
    if (code[1])       result = 1'b1;
    else if (code[0])  result = 1'b0;
    else               result = dir;
    return result;
  endfunction

endpackage

// File: rtl/ow_trip_ctrl.sv
module ow_trip_ctrl
  import ow_trip_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic slot_done_i,
  output logic busy_o,
  output logic rd_req_o,
  output logic wr_req_o,
  output logic done_o,
  output logic accept_o,
  output logic cap_first_o,
  output logic cap_second_o
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i)     state_d = ST_READA;
      ST_READA: if (slot_done_i) state_d = ST_READB;
      ST_READB: if (slot_done_i) state_d = ST_WRITE;
      ST_WRITE: if (slot_done_i) state_d = ST_FIN;
      ST_FIN:                    state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign rd_req_o     = (state_q == ST_READA) || (state_q == ST_READB);
  assign wr_req_o     = (state_q == ST_WRITE);
  assign done_o       = (state_q == ST_FIN);
  assign accept_o     = (state_q == ST_IDLE) && start_i;
  assign cap_first_o  = (state_q == ST_READA) && slot_done_i;
  assign cap_second_o = (state_q == ST_READB) && slot_done_i;

  // R1: never two requests at once, and no request alongside done
  assert_one_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_o, wr_req_o, done_o}));

  // R1: a pending request is held until acknowledged
  assert_req_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !slot_done_i) |=> rd_req_o);

  // R6: done is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: acknowledged write slot is followed by done
  assert_done_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && slot_done_i) |=> done_o);

  // R9: the accepted start raises a read request on the next cycle
  assert_first_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (rd_req_o && busy_o));

endmodule

// File: rtl/ow_trip_capture.sv
module ow_trip_capture
  import ow_trip_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept_i,
  input  logic                dir_i,
  input  logic                cap_first_i,
  input  logic                cap_second_i,
  input  logic                bit_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                wr_bit_o
);

  logic                dir_q;
  logic [STATUS_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      code_q <= '0;
    end else begin
      if (accept_i)     dir_q     <= dir_i;
      if (cap_first_i)  code_q[1] <= bit_i;
      if (cap_second_i) code_q[0] <= bit_i;
    end
  end

  assign status_o = code_q;
  assign wr_bit_o = pick_write_bit(code_q, dir_q);

  // R2: first captured bit lands in the high status bit
  assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_first_i |=> (code_q[1] == $past(bit_i)));

  // R2: second captured bit lands in the low status bit
  assert_second_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_second_i |=> (code_q[0] == $past(bit_i)));

endmodule

// File: rtl/ow_triplet_seq.sv
module ow_triplet_seq
  import ow_trip_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       dir_i,
  output logic       busy_o,
  output logic       rd_req_o,
  output logic       wr_req_o,
  output logic       wr_bit_o,
  input  logic       slot_done_i,
  input  logic       rd_bit_i,
  output logic       done_o,
  output logic [1:0] status_o
);

  logic accept_w;
  logic cap_first_w;
  logic cap_second_w;
  logic [STATUS_W-1:0] code_w;

  ow_trip_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .slot_done_i  (slot_done_i),
    .busy_o       (busy_o),
    .rd_req_o     (rd_req_o),
    .wr_req_o     (wr_req_o),
    .done_o       (done_o),
    .accept_o     (accept_w),
    .cap_first_o  (cap_first_w),
    .cap_second_o (cap_second_w)
  );

  ow_trip_capture u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept_w),
    .dir_i        (dir_i),
    .cap_first_i  (cap_first_w),
    .cap_second_i (cap_second_w),
    .bit_i        (rd_bit_i),
    .status_o     (code_w),
    .wr_bit_o     (wr_bit_o)
  );

  assign status_o = code_w;

  // R4: code 01 always writes zero
  assert_write_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && code_w == 2'b01) |-> !wr_bit_o);

  // R5: a set first bit always writes one
  assert_write_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && code_w[1]) |-> wr_bit_o);

  // R7: status does not move while idle
  assert_idle_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(status_o));

  // R7: start during an operation does not restart it
  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

endmodule

// File: tb/ow_triplet_seq_test.sv
`timescale 1ns/1ps
module ow_triplet_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       dir_i = 1'b0;
  logic       busy_o, rd_req_o, wr_req_o, wr_bit_o, done_o;
  logic       slot_done_i, rd_bit_i;
  logic [1:0] status_o;

  logic slave_done = 1'b0;
  logic stray_done = 1'b0;
  assign slot_done_i = slave_done | stray_done;

  always #2 clk = ~clk;

  ow_triplet_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
    .busy_o(busy_o), .rd_req_o(rd_req_o), .wr_req_o(wr_req_o),
    .wr_bit_o(wr_bit_o), .slot_done_i(slot_done_i), .rd_bit_i(rd_bit_i),
    .done_o(done_o), .status_o(status_o)
  );

  int checks = 0;
  int errors = 0;

  // Bit-layer model
  int   lat = 1;
  logic ans_a = 1'b0, ans_b = 1'b0;
  int   cnt = 0;
  int   nreads = 0;
  int   nslots = 0;
  int   slot_kind [0:15];
  logic wbit_seen = 1'b0;
  logic rbit = 1'b0;
  assign rd_bit_i = rbit;

  always @(negedge clk) begin
    if (slave_done) begin
      slave_done <= 1'b0;
      cnt = 0;
    end else if (rd_req_o || wr_req_o) begin
      cnt++;
      if (cnt >= lat) begin
        slave_done <= 1'b1;
        if (nslots < 16) slot_kind[nslots] = rd_req_o ? 0 : 1;
        nslots++;
        if (rd_req_o) begin
          rbit <= (nreads == 0) ? ans_a : ans_b;
          nreads++;
        end else begin
          wbit_seen = wr_bit_o;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic expect_wbit(input logic a, input logic b, input logic d);
    case ({a, b})
      2'b00:   return d;
      2'b01:   return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // One operation; optional extra start pulse mid-operation
  task automatic run_op(input logic a, input logic b, input logic d,
                        input int l, input bit poke);
    int k;
    int done_k;
    int pulses;
    ans_a = a; ans_b = b; lat = l;
    nreads = 0; nslots = 0; cnt = 0;
    @(negedge clk);
    start_i = 1'b1; dir_i = d;
    k = 0; done_k = -1; pulses = 0;
    while (k < 60) begin
      @(negedge clk);
      k++;
      start_i = (poke && k == 3) ? 1'b1 : 1'b0;
      dir_i   = (poke && k == 3) ? ~d : d;
      if (done_o) begin
        pulses++;
        if (done_k < 0) begin
          done_k = k;
          check(status_o == {a, b}, "R2 status", status_o, {a, b});
        end
      end
      if (done_k >= 0 && k >= done_k + 5) break;
    end
    start_i = 1'b0;
    check(done_k == 3*l + 3, "R9 done timing", done_k, 3*l + 3);
    check(pulses == 1, "R6 single done", pulses, 1);
    check(nslots == 3 && slot_kind[0] == 0 && slot_kind[1] == 0 && slot_kind[2] == 1,
          "R1 slot order", nslots, 3);
    check(wbit_seen == expect_wbit(a, b, d),
          ({a, b} == 2'b00) ? "R3 write dir" : ({a, b} == 2'b01) ? "R4 write 0" : "R5 write 1",
          wbit_seen, expect_wbit(a, b, d));
    check(!busy_o && status_o == {a, b}, "R6 status held", status_o, {a, b});
  endtask

  // {first, second, dir, latency}
  localparam logic [5:0] VEC [0:7] = '{
    {1'b0, 1'b0, 1'b0, 3'd1}, {1'b0, 1'b0, 1'b1, 3'd2},
    {1'b0, 1'b1, 1'b1, 3'd1}, {1'b0, 1'b1, 1'b0, 3'd3},
    {1'b1, 1'b0, 1'b0, 3'd2}, {1'b1, 1'b0, 1'b1, 3'd1},
    {1'b1, 1'b1, 1'b0, 3'd4}, {1'b1, 1'b1, 1'b1, 3'd1}
  };

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(!busy_o && !rd_req_o && !wr_req_o && !done_o, "R8 reset outputs",
          {busy_o, rd_req_o, wr_req_o, done_o}, 0);
    check(status_o == 2'b00, "R8 reset status", status_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++)
      run_op(VEC[i][5], VEC[i][4], VEC[i][3], int'(VEC[i][2:0]), 1'b0);

    // R7: start while busy is ignored (second start with inverted dir)
    run_op(1'b0, 1'b0, 1'b1, 2, 1'b1);

    // R7: stray acknowledge while idle
    nslots = 0;
    @(negedge clk); stray_done = 1'b1;
    @(negedge clk); stray_done = 1'b0;
    repeat (4) @(negedge clk);
    check(!busy_o && !rd_req_o && !wr_req_o && nslots == 0, "R7 stray ack",
          busy_o, 0);
    check(status_o == 2'b00, "R7 stray ack status", status_o, 0);

    // R5: all-ones again after a different code
    run_op(1'b1, 1'b1, 1'b0, 1, 1'b0);
    finished = 1'b1;
  end

  initial begin
    int t = 0;
    while (!finished && t < 20000) begin
      @(posedge clk);
      t++;
    end
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", t, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule